// File: doc/BRIEF.md
# DRAM Bank Precharge Tracker

This block watches the command strobes a memory controller sends to a four-bank graphics DRAM and keeps its own copy of which banks hold an open row. Row-open commands and row-close commands are decoded from chip-select, RAS, CAS and WE together with address bit A8 and the two bank-address bits. A row-close can target one bank or every bank at once, depending on A8.

Each bank is tracked by a small state machine with three named states: IDLE (closed and ready), OPEN (a row is active), and RECOVER (closed, but the close-to-open recovery time has not yet run out). The transitions are IDLE to OPEN on an activate, OPEN to RECOVER on a close (or straight to IDLE when the recovery time is one cycle), and RECOVER to IDLE when the bank's own down-counter expires. Every other command leaves a bank where it is.

The controller or a monitor uses the outputs to see the open-bank mask and to catch protocol misuse. A sticky error flag is raised when an activate hits a bank that is not IDLE, or when a read or write hits a bank that is not OPEN. Only reset clears this flag.

Top module: `bank_precharge_tracker`

## Requirements
- R1: After reset, every bank is IDLE, `open_mask` is 0, `any_open` is 0 and `proto_err` is 0.
- R2: A command is decoded only when `cs_n` is 0. The strobe codes (`ras_n`,`cas_n`,`we_n`) are: activate 0,1,1; precharge 0,1,0; read 1,0,1; write 1,0,0. When `cs_n` is 1, or for any other code, nothing changes.
- R3: An activate to an IDLE bank sets bit `ba` of `open_mask`, which becomes visible after the clock edge that samples the command.
- R4: A precharge with `a8` = 0 closes only the bank that `ba` selects. The other banks keep their state.
- R5: A precharge with `a8` = 1 closes every open bank, and the value of `ba` has no effect.
- R6: Once an OPEN bank is precharged at edge k, it accepts a new activate at edge k+TRP_CYC or later. An activate at an earlier edge raises the error flag and does not open the bank.
- R7: An activate to a bank that is already OPEN raises the error flag and leaves `open_mask` unchanged.
- R8: A read or write to a bank that is not OPEN (IDLE or RECOVER) raises the error flag. A read or write to an OPEN bank does not raise it.
- R9: `proto_err` stays at 1 until reset, even while later commands are legal.
- R10: `any_open` is 1 exactly when at least one bit of `open_mask` is 1.
- R11: A precharge to a bank that is IDLE or RECOVER has no effect. It does not restart the recovery time and does not raise the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| a8 | input | 1 | Precharge scope: 0 closes one bank, 1 closes all banks |
| ba | input | 2 | Bank address |
| open_mask | output | 4 | One bit per bank, 1 when the bank is OPEN |
| any_open | output | 1 | 1 when any bank is OPEN |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
On every cycle, the assertions check that a bank only opens from IDLE, that closing an OPEN bank moves it into recovery, that the recovery counter stays in range, that a close-all empties the mask, that misuse of a bank sets the error flag, and that the flag never drops. Only the bench's scenarios can show the exact edge at which an activate becomes legal after a close. They also show that a repeated close does not stretch the recovery time, that `ba` has no effect on a close-all, and that deselected strobes leave the state untouched.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_PRE,
        CMD_RD,
        CMD_WR
    } dram_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_RECOVER
    } bank_st_e;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_trk_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output dram_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/bank_slot.sv
module bank_slot
    import bank_trk_pkg::*;
#(
    parameter int TRP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_sel,
    input  logic pre_sel,
    input  logic rw_sel,
    output logic is_open,
    output logic fault
);

    localparam int  CW       = (TRP_CYC < 2) ? 1 : $clog2(TRP_CYC + 1);
    localparam bit  SKIP_REC = (TRP_CYC <= 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'((TRP_CYC > 1) ? TRP_CYC - 1 : 1);

    bank_st_e        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_sel) st_d = BK_OPEN;
            end
            BK_OPEN: begin
                if (pre_sel) begin
                    if (SKIP_REC) begin
                        st_d = BK_IDLE;
                    end else begin
                        st_d  = BK_RECOVER;
                        cnt_d = LOAD_VAL;
                    end
                end
            end
            BK_RECOVER: begin
                if (cnt_q == CW'(1)) begin
                    st_d  = BK_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        is_open = (st_q == BK_OPEN);
        fault   = (act_sel && st_q != BK_IDLE) || (rw_sel && st_q != BK_OPEN);
    end

    a_r3_open_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> ($past(st_q) == BK_IDLE) && $past(act_sel));

    a_r4_close_enters_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN && pre_sel) |=> (st_q == (SKIP_REC ? BK_IDLE : BK_RECOVER)));

    a_r6_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_RECOVER) |-> (cnt_q != '0) && (cnt_q < CW'(TRP_CYC)));

    a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_RECOVER && cnt_q != CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/bank_precharge_tracker.sv
module bank_precharge_tracker
    import bank_trk_pkg::*;
#(
    parameter int TRP_CYC = 4,
    parameter int BA_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   a8,
    input  logic [BA_W-1:0]        ba,
    output logic [(1<<BA_W)-1:0]   open_mask,
    output logic                   any_open,
    output logic                   proto_err
);

    localparam int NBANK = 1 << BA_W;

    dram_cmd_e          cmd;
    logic [NBANK-1:0]   fault_vec;
    logic               err_q;

    bank_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        logic act_sel, pre_sel, rw_sel;

        always_comb begin
            hit     = (ba == BA_W'(b));
            act_sel = (cmd == CMD_ACT) && hit;
            pre_sel = (cmd == CMD_PRE) && (a8 || hit);
            rw_sel  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && hit;
        end

        bank_slot #(.TRP_CYC(TRP_CYC)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_sel (act_sel),
            .pre_sel (pre_sel),
            .rw_sel  (rw_sel),
            .is_open (open_mask[b]),
            .fault   (fault_vec[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (|fault_vec);
    end

    always_comb begin
        any_open  = |open_mask;
        proto_err = err_q;
    end

    a_r5_close_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && a8) |=> (open_mask == '0));

    a_r7_double_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && open_mask[ba]) |=> proto_err && (open_mask == $past(open_mask)));

    a_r8_access_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && !open_mask[ba]) |=> proto_err);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

// File: tb/bank_precharge_tracker_tb.sv
module bank_precharge_tracker_tb;

    localparam int TRP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a8 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] open_mask;
    logic       any_open, proto_err;

    always #4 clk = ~clk;

    bank_precharge_tracker #(.TRP_CYC(TRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a8(a8), .ba(ba), .open_mask(open_mask),
        .any_open(any_open), .proto_err(proto_err)
    );

    typedef struct {
        logic [3:0] m;
        logic       e;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;

    typedef enum int {K_NOP, K_ACT, K_PRE, K_RD, K_WR, K_DESEL} kind_e;

    // Driver: one command per cycle, expected outcome queued
    task automatic issue(kind_e k, int b, bit all, logic [3:0] em, logic ee, string tag);
        exp_t it;
        @(negedge clk);
        cs_n = 1'b0; a8 = all; ba = 2'(b);
        case (k)
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            K_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        it.m = em; it.e = ee; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; a8 = 1'b0; ba = 2'd0;
        repeat (2) @(negedge clk);
        n_chk++;
        if (open_mask !== 4'b0 || any_open !== 1'b0 || proto_err !== 1'b0) begin
            n_err++;
            $display("FAIL R1 reset: mask=%b any=%b err=%b exp mask=0000 any=0 err=0",
                     open_mask, any_open, proto_err);
        end
        rst_n = 1'b1;
    endtask

    // Monitor: compare after each sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_chk++;
                if (open_mask !== it.m || proto_err !== it.e || any_open !== (|it.m)) begin
                    n_err++;
                    $display("FAIL %s: mask=%b any=%b err=%b exp mask=%b any=%b err=%b",
                             it.tag, open_mask, any_open, proto_err, it.m, |it.m, it.e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run hung, exp completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R3 / R8 / R2 / R10
        issue(K_ACT, 0, 0, 4'b0001, 0, "R3 act b0");
        issue(K_ACT, 2, 0, 4'b0101, 0, "R3 act b2 R10");
        issue(K_RD,  0, 0, 4'b0101, 0, "R8 read open b0");
        issue(K_WR,  2, 0, 4'b0101, 0, "R8 write open b2");
        issue(K_DESEL, 1, 0, 4'b0101, 0, "R2 deselected act b1");
        // R4 single close
        issue(K_PRE, 2, 0, 4'b0001, 0, "R4 close b2 only");
        issue(K_ACT, 1, 0, 4'b0011, 0, "R3 act b1");
        issue(K_ACT, 3, 0, 4'b1011, 0, "R3 act b3");
        // R5 close all, ba ignored (points at closed bank 2)
        issue(K_PRE, 2, 1, 4'b0000, 0, "R5 close all ba=2");
        // R6 on-time activate at k+TRP
        for (int i = 1; i < TRP; i++) issue(K_NOP, 0, 0, 4'b0000, 0, "R6 wait");
        issue(K_ACT, 0, 0, 4'b0001, 0, "R6 act at tRP");
        // R7 double activate
        issue(K_ACT, 0, 0, 4'b0001, 1, "R7 act open b0");
        issue(K_NOP, 0, 0, 4'b0001, 1, "R9 sticky");
        do_reset();
        // R6 early activate
        issue(K_ACT, 1, 0, 4'b0010, 0, "R3 act b1");
        issue(K_PRE, 1, 0, 4'b0000, 0, "R4 close b1");
        for (int i = 1; i < TRP - 1; i++) issue(K_NOP, 0, 0, 4'b0000, 0, "R6 wait");
        issue(K_ACT, 1, 0, 4'b0000, 1, "R6 act before tRP");
        do_reset();
        // R11 repeated close does not restart recovery
        issue(K_ACT, 0, 0, 4'b0001, 0, "R3 act b0");
        issue(K_PRE, 0, 0, 4'b0000, 0, "R4 close b0");
        issue(K_NOP, 0, 0, 4'b0000, 0, "R11 wait");
        issue(K_PRE, 0, 0, 4'b0000, 0, "R11 close recovering b0");
        issue(K_PRE, 3, 0, 4'b0000, 0, "R11 close idle b3");
        issue(K_ACT, 0, 0, 4'b0001, 0, "R11 act at original tRP");
        do_reset();
        // R8 read idle, R9 sticky across legal traffic
        issue(K_RD,  2, 0, 4'b0000, 1, "R8 read idle b2");
        issue(K_NOP, 0, 0, 4'b0000, 1, "R9 sticky nop");
        issue(K_ACT, 2, 0, 4'b0100, 1, "R9 sticky legal act");
        do_reset();
        // R8 write to recovering bank
        issue(K_ACT, 3, 0, 4'b1000, 0, "R3 act b3");
        issue(K_PRE, 3, 0, 4'b0000, 0, "R4 close b3");
        issue(K_WR,  3, 0, 4'b0000, 1, "R8 write recovering b3");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule